// File: doc/BRIEF.md
# NAND Strobe and Chip-Select Decoder

This block connects a simple memory-mapped host bus to the raw 8-bit bus of NAND flash devices. A host byte write into the bank window becomes one bus cycle on the flash side. Two offset bits of the write address pick what kind of cycle it is:

- a command cycle, with the command latch line high;
- an address cycle, with the address latch line high;
- a plain data cycle, when neither bit is set.

A host read from the bank window performs one data read cycle and returns the byte it captured. Each cycle is a write-enable or read-enable low pulse of a fixed, parameterised number of clocks.

A small register space sits beside the bank window. The chip control register holds an enable bit and a select-assert bit for every chip. The active-low chip-enable pins are decoded from these bit pairs. A status register shows the level of the ready/busy input after a synchroniser.

The host starts an access with a one-clock request. The access ends with a one-clock done pulse, which carries read data and an error flag. While a flash cycle is in progress the block reports busy, and it drops any new request.

Top module: `nand_strobe_decoder`

## Requirements
- R1: After reset, all chip-enable pins are high, the write-enable and read-enable pins are high, both latch lines are low, the data bus is not driven, busy is low and the control register reads 0.
- R2: A bank write whose offset has bit 16 set and bit 15 clear is issued as an address cycle. The address latch line is high and the command latch line is low for the whole write-enable pulse.
- R3: A bank write whose offset has bit 15 set and bit 16 clear is issued as a command cycle. The command latch line is high and the address latch line is low for the whole pulse.
- R4: A bank write with neither bit 15 nor bit 16 set is a data cycle, and both latch lines stay low.
- R5: A bank write with both bit 15 and bit 16 set produces no flash cycle. It completes with done and the error flag high in the same clock.
- R6: A bank write drives write-enable low for exactly PULSE_CLKS clocks and drives the written byte onto the data bus. The byte stays on the bus with output enable, together with the latch lines, for one clock after write-enable rises.
- R7: A bank read drives read-enable low for exactly PULSE_CLKS clocks and does not drive the data bus. It captures the data bus on the last clock of that pulse and returns the byte on the read data port together with done.
- R8: The chip control register is at register offset 0x50. For chip n, bit 2n is the enable and bit 2n+1 is the select assert. Chip-enable pin n is low only when both bits are 1. The register reads back the written value.
- R9: Writing zero to the chip control register drives every chip-enable pin high.
- R10: The status register at register offset 0x54 returns the synchronised ready/busy level in bit 0, where 1 means ready. Its other bits read 0.
- R11: A request presented while busy is high is ignored. It causes no flash cycle and no done pulse.
- R12: The command and address latch lines are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | One-clock access request |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_bank | input | 1 | 1 = bank window, 0 = register space |
| h_addr | input | 17 | Offset inside the selected space |
| h_wdata | input | 8 | Write byte |
| h_rdata | output | 8 | Read byte, valid with done |
| h_done | output | 1 | One-clock completion pulse |
| h_err | output | 1 | Illegal bank window flag, valid with done |
| h_busy | output | 1 | Flash cycle in progress |
| nand_ce_n | output | CHIPS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write enable |
| nand_re_n | output | 1 | Active-low read enable |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Ready/busy level, 1 = ready |

## Verification
The hardest condition to reach from the ports is a second request that arrives while the engine is in the middle of a strobe. The bench raises a request a clock after a write has been accepted. It then watches a full idle window afterwards to confirm that no extra pulse and no extra done appeared.

Read capture timing is also hard to observe. The bench model changes the data bus only on the last low clock of read-enable, so a capture on any earlier clock returns the complemented byte.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

    localparam int HADDR_W  = 17;
    localparam int DQ_W     = 8;
    localparam int ALE_BIT  = 16;
    localparam int CLE_BIT  = 15;
    localparam logic [HADDR_W-1:0] CTRL_OFS = 17'h00050;
    localparam logic [HADDR_W-1:0] STAT_OFS = 17'h00054;

    typedef enum logic [1:0] {
        CYC_DATA = 2'd0,
        CYC_CMD  = 2'd1,
        CYC_ADDR = 2'd2
    } cyc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_HOLD   = 2'd2
    } eng_state_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      bad;
    } win_dec_t;

    typedef struct packed {
        logic            rd;
        cyc_kind_e       kind;
        logic [DQ_W-1:0] data;
    } nand_op_t;

    function automatic win_dec_t decode_window(input logic [HADDR_W-1:0] a);
        win_dec_t d;
        d.bad  = a[ALE_BIT] & a[CLE_BIT];
        if (a[ALE_BIT] && !a[CLE_BIT])
            d.kind = CYC_ADDR;
        else if (a[CLE_BIT] && !a[ALE_BIT])
            d.kind = CYC_CMD;
        else
            d.kind = CYC_DATA;
        return d;
    endfunction

endpackage

// File: rtl/nand_chip_ctrl.sv
module nand_chip_ctrl #(
    parameter int CHIPS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [2*CHIPS-1:0] wr_data,
    output logic [2*CHIPS-1:0] ctrl_q,
    output logic [CHIPS-1:0]   ce_n
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_data;
    end

    // Bit pair per chip: even bit = enable, odd bit = select assert
    for (genvar n = 0; n < CHIPS; n++) begin : g_chip
        assign ce_n[n] = ~(ctrl_q[2*n] & ctrl_q[2*n+1]);
    end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_in,
    output logic rb_q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[STAGES-2:0], rb_in};
    end

    assign rb_q = sh[STAGES-1];
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
    import nand_dec_pkg::*;
#(
    parameter int PULSE_CLKS = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  nand_op_t        op,
    output logic            busy,
    output logic            fin,
    output logic            fin_rd,
    output logic [DQ_W-1:0] cap_data,
    output logic            we_n,
    output logic            re_n,
    output logic            cle,
    output logic            ale,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe,
    input  logic [DQ_W-1:0] dq_in
);
    localparam int CNT_W = (PULSE_CLKS < 2) ? 1 : $clog2(PULSE_CLKS);

    eng_state_e       state;
    nand_op_t         op_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op_q     <= '0;
            cnt      <= '0;
            fin      <= 1'b0;
            fin_rd   <= 1'b0;
            cap_data <= '0;
        end else begin
            fin    <= 1'b0;
            fin_rd <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q  <= op;
                        cnt   <= CNT_W'(PULSE_CLKS - 1);
                        state <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (cnt == '0) begin
                        state <= ST_HOLD;
                        if (op_q.rd)
                            cap_data <= dq_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    state  <= ST_IDLE;
                    fin    <= 1'b1;
                    fin_rd <= op_q.rd;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    logic active_wr;
    assign busy      = (state != ST_IDLE);
    assign active_wr = busy && !op_q.rd;
    assign we_n      = ~((state == ST_STROBE) && !op_q.rd);
    assign re_n      = ~((state == ST_STROBE) &&  op_q.rd);
    assign cle       = active_wr && (op_q.kind == CYC_CMD);
    assign ale       = active_wr && (op_q.kind == CYC_ADDR);
    assign dq_oe     = active_wr;
    assign dq_out    = op_q.data;
endmodule

// File: rtl/nand_strobe_decoder.sv
module nand_strobe_decoder
    import nand_dec_pkg::*;
#(
    parameter int CHIPS       = 4,
    parameter int PULSE_CLKS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_req,
    input  logic               h_wr,
    input  logic               h_bank,
    input  logic [16:0]        h_addr,
    input  logic [7:0]         h_wdata,
    output logic [7:0]         h_rdata,
    output logic               h_done,
    output logic               h_err,
    output logic               h_busy,
    output logic [CHIPS-1:0]   nand_ce_n,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_we_n,
    output logic               nand_re_n,
    output logic [7:0]         nand_dq_out,
    output logic               nand_dq_oe,
    input  logic [7:0]         nand_dq_in,
    input  logic               nand_rb
);
    localparam int CTRL_W = 2 * CHIPS;

    logic [CTRL_W-1:0] ctrl_q;
    logic              rb_s;
    logic              eng_busy, eng_fin, eng_fin_rd;
    logic [DQ_W-1:0]   eng_cap;
    logic              accept, start, ctrl_wr, bad_wr;
    win_dec_t          dec;
    nand_op_t          op;
    logic [DQ_W-1:0]   reg_rd;
    logic [DQ_W-1:0]   rdata_q;
    logic              done_q, err_q;

    assign accept  = h_req && !eng_busy;
    assign dec     = decode_window(h_addr);
    assign bad_wr  = h_wr && dec.bad;
    assign start   = accept && h_bank && !bad_wr;
    assign ctrl_wr = accept && !h_bank && h_wr && (h_addr == CTRL_OFS);

    always_comb begin
        op.rd   = !h_wr;
        op.kind = h_wr ? dec.kind : CYC_DATA;
        op.data = h_wdata;
    end

    always_comb begin
        if (h_addr == CTRL_OFS)
            reg_rd = DQ_W'(ctrl_q);
        else if (h_addr == STAT_OFS)
            reg_rd = DQ_W'(rb_s);
        else
            reg_rd = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept && !h_bank) begin
                done_q <= 1'b1;
                if (!h_wr)
                    rdata_q <= reg_rd;
            end else if (accept && h_bank && bad_wr) begin
                done_q <= 1'b1;
                err_q  <= 1'b1;
            end
            if (eng_fin) begin
                done_q <= 1'b1;
                if (eng_fin_rd)
                    rdata_q <= eng_cap;
            end
        end
    end

    nand_chip_ctrl #(.CHIPS(CHIPS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr),
        .wr_data (h_wdata[CTRL_W-1:0]),
        .ctrl_q  (ctrl_q),
        .ce_n    (nand_ce_n)
    );

    nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
        .clk   (clk),
        .rst   (rst),
        .rb_in (nand_rb),
        .rb_q  (rb_s)
    );

    nand_cycle_engine #(.PULSE_CLKS(PULSE_CLKS)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op       (op),
        .busy     (eng_busy),
        .fin      (eng_fin),
        .fin_rd   (eng_fin_rd),
        .cap_data (eng_cap),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .dq_out   (nand_dq_out),
        .dq_oe    (nand_dq_oe),
        .dq_in    (nand_dq_in)
    );

    assign h_rdata = rdata_q;
    assign h_done  = done_q;
    assign h_err   = err_q;
    assign h_busy  = eng_busy;
endmodule

// File: rtl/nand_strobe_checker.sv
module nand_strobe_checker #(
    parameter int CHIPS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             h_req,
    input logic             h_wr,
    input logic             h_bank,
    input logic [16:0]      h_addr,
    input logic [7:0]       h_wdata,
    input logic             h_done,
    input logic             h_err,
    input logic             h_busy,
    input logic [CHIPS-1:0] nand_ce_n,
    input logic             nand_cle,
    input logic             nand_ale,
    input logic             nand_we_n,
    input logic             nand_re_n,
    input logic [7:0]       nand_dq_out,
    input logic             nand_dq_oe
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe));

    p_err_with_done_r5: assert property (@(posedge clk) disable iff (rst)
        h_err |-> (h_done && nand_we_n));

    p_drive_in_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        !nand_we_n |-> nand_dq_oe);

    p_hold_after_we_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (nand_dq_oe && $stable(nand_dq_out)
                              && $stable(nand_cle) && $stable(nand_ale)));

    p_read_no_drive_r7: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> (!nand_dq_oe && nand_we_n));

    p_zero_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
        (h_req && !h_busy && !h_bank && h_wr && h_addr == 17'h00050
         && h_wdata == 8'h00) |=> &nand_ce_n);

    p_strobe_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> h_busy);

    p_latch_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));
endmodule

bind nand_strobe_decoder nand_strobe_checker #(.CHIPS(CHIPS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .h_req       (h_req),
    .h_wr        (h_wr),
    .h_bank      (h_bank),
    .h_addr      (h_addr),
    .h_wdata     (h_wdata),
    .h_done      (h_done),
    .h_err       (h_err),
    .h_busy      (h_busy),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_out (nand_dq_out),
    .nand_dq_oe  (nand_dq_oe)
);

// File: tb/sim_nand_strobe_decoder.sv
`timescale 1ns/1ps
module sim_nand_strobe_decoder;
    localparam int CHIPS = 4;
    localparam int PULSE = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             h_req = 1'b0, h_wr = 1'b0, h_bank = 1'b0;
    logic [16:0]      h_addr = '0;
    logic [7:0]       h_wdata = '0;
    logic [7:0]       h_rdata;
    logic             h_done, h_err, h_busy;
    logic [CHIPS-1:0] nand_ce_n;
    logic             nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]       nand_dq_out;
    logic [7:0]       nand_dq_in = 8'h00;
    logic             nand_rb = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    nand_strobe_decoder #(.CHIPS(CHIPS), .PULSE_CLKS(PULSE), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .h_req(h_req), .h_wr(h_wr), .h_bank(h_bank),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_done(h_done),
        .h_err(h_err), .h_busy(h_busy), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
        .nand_rb(nand_rb)
    );

    // Results of the last access
    int         we_lo, re_lo, cle_cnt, ale_cnt, oe_bad;
    logic       hold_seen, hold_ok, got_done, got_err;
    logic [7:0] dq_seen, got_rd;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [CHIPS-1:0] exp_ce(input logic [7:0] c);
        logic [CHIPS-1:0] r;
        for (int n = 0; n < CHIPS; n++) r[n] = !(c[2*n] && c[2*n+1]);
        return r;
    endfunction

    // Called at a negedge. Optional second request during the strobe.
    task automatic access(input logic bank, input logic wr, input logic [16:0] addr,
                          input logic [7:0] wd, input logic [7:0] rd_val,
                          input bit poke_busy);
        logic prev_we;
        we_lo = 0; re_lo = 0; cle_cnt = 0; ale_cnt = 0; oe_bad = 0;
        hold_seen = 0; hold_ok = 0; got_done = 0; got_err = 0;
        dq_seen = 8'h00; got_rd = 8'h00; prev_we = 1'b1;
        nand_dq_in = ~rd_val;
        h_req = 1'b1; h_wr = wr; h_bank = bank; h_addr = addr; h_wdata = wd;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            h_req = 1'b0;
            if (poke_busy && i == 1) begin
                h_req = 1'b1; h_wr = 1'b1; h_bank = 1'b1;
                h_addr = 17'h08000; h_wdata = ~wd;
            end
            if (!nand_we_n) begin
                we_lo++;
                dq_seen = nand_dq_out;
                if (!nand_dq_oe) oe_bad++;
                if (nand_cle) cle_cnt++;
                if (nand_ale) ale_cnt++;
            end
            if (!nand_re_n) begin
                re_lo++;
                if (nand_dq_oe) oe_bad++;
                nand_dq_in = (re_lo == PULSE) ? rd_val : ~rd_val;
            end else begin
                nand_dq_in = ~rd_val;
            end
            if (nand_we_n && !prev_we) begin
                hold_seen = 1'b1;
                hold_ok = nand_dq_oe && (nand_dq_out == dq_seen);
            end
            prev_we = nand_we_n;
            if (h_done) begin
                got_done = 1'b1; got_err = h_err; got_rd = h_rdata;
                break;
            end
        end
        h_req = 1'b0;
    endtask

    task automatic check_bank_write(input logic [1:0] win, input logic [14:0] low,
                                    input logic [7:0] d);
        logic [16:0] a;
        a = {win[1], win[0], low};
        access(1'b1, 1'b1, a, d, 8'h00, 1'b0);
        check(got_done, "R6", "done", got_done, 1);
        if (win == 2'b11) begin
            check(got_err && we_lo == 0 && cle_cnt == 0 && ale_cnt == 0, "R5",
                  "illegal window", {got_err, 8'(we_lo)}, 9'h100);
        end else begin
            check(!got_err && we_lo == PULSE, "R6", "we pulse len", we_lo, PULSE);
            check(dq_seen == d && oe_bad == 0, "R6", "data byte", dq_seen, d);
            check(hold_seen && hold_ok, "R6", "hold after we", hold_ok, 1);
            if (win == 2'b10)
                check(ale_cnt == PULSE && cle_cnt == 0, "R2", "addr cycle",
                      {ale_cnt[3:0], cle_cnt[3:0]}, {PULSE[3:0], 4'h0});
            else if (win == 2'b01)
                check(cle_cnt == PULSE && ale_cnt == 0, "R3", "cmd cycle",
                      {cle_cnt[3:0], ale_cnt[3:0]}, {PULSE[3:0], 4'h0});
            else
                check(cle_cnt == 0 && ale_cnt == 0, "R4", "data cycle",
                      {cle_cnt[3:0], ale_cnt[3:0]}, 0);
        end
    endtask

    task automatic check_bank_read(input logic [7:0] v);
        access(1'b1, 1'b0, 17'h00000, 8'h00, v, 1'b0);
        check(got_done && re_lo == PULSE && we_lo == 0 && oe_bad == 0, "R7",
              "re pulse len", re_lo, PULSE);
        check(got_rd == v, "R7", "captured byte", got_rd, v);
    endtask

    task automatic check_ctrl(input logic [7:0] c);
        access(1'b0, 1'b1, 17'h00050, c, 8'h00, 1'b0);
        check(got_done && !got_err, "R8", "ctrl write done", got_done, 1);
        check(nand_ce_n == exp_ce(c), "R8", "ce decode", nand_ce_n, exp_ce(c));
        access(1'b0, 1'b0, 17'h00050, 8'h00, 8'h00, 1'b0);
        check(got_rd == c, "R8", "ctrl readback", got_rd, c);
    endtask

    initial begin
        void'($urandom(32'h5eed_1a7e));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(nand_ce_n == 4'hF && nand_we_n && nand_re_n && !nand_cle && !nand_ale
              && !nand_dq_oe && !h_busy && !h_done, "R1", "idle pins",
              {nand_ce_n, nand_we_n, nand_re_n}, 6'h3F);
        access(1'b0, 1'b0, 17'h00050, 8'h00, 8'h00, 1'b0);
        check(got_rd == 8'h00, "R1", "ctrl after reset", got_rd, 0);

        // Directed cycle kinds
        check_bank_write(2'b10, 15'h0000, 8'hA5);   // R2
        check_bank_write(2'b01, 15'h0000, 8'h70);   // R3
        check_bank_write(2'b00, 15'h0000, 8'h3C);   // R4
        check_bank_write(2'b11, 15'h0000, 8'h11);   // R5
        check_bank_read(8'hC3);                      // R7

        // R8 chip control decode
        check_ctrl(8'b0000_0011);
        check_ctrl(8'b1110_0100);
        check_ctrl(8'hFF);
        // R9 zero clears all
        check_ctrl(8'h00);
        check(nand_ce_n == 4'hF, "R9", "all deasserted", nand_ce_n, 4'hF);

        // R10 ready/busy status
        nand_rb = 1'b1;
        repeat (4) @(negedge clk);
        access(1'b0, 1'b0, 17'h00054, 8'h00, 8'h00, 1'b0);
        check(got_rd == 8'h01, "R10", "ready level", got_rd, 1);
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        access(1'b0, 1'b0, 17'h00054, 8'h00, 8'h00, 1'b0);
        check(got_rd == 8'h00, "R10", "busy level", got_rd, 0);

        // R11 request while busy is dropped
        access(1'b1, 1'b1, 17'h00000, 8'h5A, 8'h00, 1'b1);
        check(got_done && we_lo == PULSE && dq_seen == 8'h5A, "R11", "first cycle",
              dq_seen, 8'h5A);
        begin
            int extra;
            extra = 0;
            for (int i = 0; i < 2 * PULSE + 6; i++) begin
                @(negedge clk);
                if (!nand_we_n || h_done || nand_cle) extra++;
            end
            check(extra == 0, "R11", "no second cycle", extra, 0);
        end

        // Random mix
        for (int k = 0; k < 60; k++) begin
            int sel;
            sel = int'($urandom % 4);
            if (sel == 0)
                check_bank_read(8'($urandom));
            else if (sel == 1)
                check_ctrl(8'($urandom));
            else
                check_bank_write(2'($urandom), 15'($urandom), 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule